// File: doc/BRIEF.md
# Four-Register Parallel Transfer Fabric

This block holds four registers of equal width and moves data between them. Every destination register owns a private multiplexer that can pick any of the other three registers, so each register has its own source choice and its own load enable. Because no source path is shared, any mix of transfers can happen on one clock edge. That includes swaps, rotations and one register copied into several others.

All transfers read the register values from before the edge, so an exchange between two registers needs no temporary storage. A synchronous initialisation port writes all four registers at once from outside, which lets a test put the bank into a known state. An asynchronous active-low reset clears the bank. The outputs are the four register values, packed side by side.

Top module: `xfer_fabric`

## Requirements
- R1: While `rst_n` is low, every register reads zero, and it stays zero until it is loaded after reset is released.
- R2: When `init_en` is high at a clock edge, register i takes slice i of `init_data` (bits i*WIDTH upward). This load takes priority over every transfer request in that cycle.
- R3: A register whose bit in `ld_en` is low, with `init_en` low, keeps its value across the edge.
- R4: The select field for destination i is `src_sel[i*2 +: 2]`. Code k selects the k-th register in ascending index order once register i itself is skipped. Register index 0 is A, 1 is B, 2 is C and 3 is D. For A the codes 0, 1 and 2 give B, C and D. For B they give A, C and D. For C they give A, B and D. For D they give A, B and C.
- R5: Select code 3 with the load enable high leaves that destination unchanged.
- R6: Every transfer samples the register values from before the edge, so A taking B while B takes A swaps the two registers in one cycle.
- R7: A four-way rotation (A takes B, B takes C, C takes D, D takes A) completes in one cycle.
- R8: Several destinations may take the same source on the same edge, and each of them receives that source's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_en | input | 1 | Synchronous direct load of all registers |
| init_data | input | NREG*WIDTH | Initial values, slice i for register i |
| ld_en | input | NREG | Per-destination load enable |
| src_sel | input | NREG*2 | Per-destination source code, 2 bits each |
| reg_q | output | NREG*WIDTH | Register values, slice i for register i |

## Verification
The bench builds the block with its default values, WIDTH of 8 and NREG of 4. With these values it can reach every pair of destination and source code, which is twelve routes, as well as the unused code 3 on each destination. The 8-bit width leaves room for a distinct byte pattern in each register, so a value on the wrong route cannot pass as a right one. Swaps, the full rotation and a copy from one source into three destinations are then applied on single edges, and each is compared with a model that reads only the old values.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_XFER = 2'd1,
    ACT_INIT = 2'd2
  } slot_act_e;

  // Map a source code of a destination to the absolute register index,
  // skipping the destination itself.
  function automatic int src_of(input int dest, input int code);
    return (code < dest) ? code : code + 1;
  endfunction

endpackage

// File: rtl/xfer_src_mux.sv
module xfer_src_mux #(
  parameter int WIDTH = 8,
  parameter int NREG  = 4,
  parameter int DEST  = 0,
  parameter int SELW  = 2
) (
  input  logic [NREG*WIDTH-1:0] all_q,
  input  logic [SELW-1:0]       sel,
  output logic [WIDTH-1:0]      src_d,
  output logic                  src_ok
);
  localparam int NSRC = NREG - 1;

  logic [WIDTH-1:0] cand [NSRC];

  for (genvar k = 0; k < NSRC; k++) begin : g_cand
    localparam int SRC = xfer_pkg::src_of(DEST, k);
    assign cand[k] = all_q[SRC*WIDTH +: WIDTH];
  end

  always_comb begin
    src_d  = '0;
    src_ok = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (sel == SELW'(k)) begin
        src_d  = cand[k];
        src_ok = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xfer_reg_slot.sv
module xfer_reg_slot #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_en,
  input  logic [WIDTH-1:0] init_d,
  input  logic             ld_en,
  input  logic             xfer_ok,
  input  logic [WIDTH-1:0] xfer_d,
  output logic [WIDTH-1:0] q
);
  import xfer_pkg::*;

  slot_act_e        act;
  logic             q_en;
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    if (init_en)               act = ACT_INIT;
    else if (ld_en && xfer_ok) act = ACT_XFER;
    else                       act = ACT_HOLD;
  end

  always_comb begin
    q_en  = 1'b0;
    q_nxt = q;
    case (act)
      ACT_INIT: begin q_en = 1'b1; q_nxt = init_d; end
      ACT_XFER: begin q_en = 1'b1; q_nxt = xfer_d; end
      default:  begin q_en = 1'b0; q_nxt = q;      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_en && !ld_en) |=> $stable(q));

  assert_bad_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_en && ld_en && !xfer_ok) |=> $stable(q));

endmodule

// File: rtl/xfer_fabric.sv
module xfer_fabric #(
  parameter int WIDTH = 8,
  parameter int NREG  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  init_en,
  input  logic [NREG*WIDTH-1:0] init_data,
  input  logic [NREG-1:0]       ld_en,
  input  logic [NREG*2-1:0]     src_sel,
  output logic [NREG*WIDTH-1:0] reg_q
);
  localparam int SELW = 2;
  localparam int NSRC = NREG - 1;

  logic [WIDTH-1:0] q_arr [NREG];
  logic [NREG*WIDTH-1:0] q_flat;

  for (genvar i = 0; i < NREG; i++) begin : g_flat
    assign q_flat[i*WIDTH +: WIDTH] = q_arr[i];
  end
  assign reg_q = q_flat;

  for (genvar d = 0; d < NREG; d++) begin : g_slot
    logic [WIDTH-1:0] src_d;
    logic             src_ok;
    logic [SELW-1:0]  sel_d;

    assign sel_d = src_sel[d*SELW +: SELW];

    xfer_src_mux #(
      .WIDTH(WIDTH), .NREG(NREG), .DEST(d), .SELW(SELW)
    ) i_mux (
      .all_q (q_flat),
      .sel   (sel_d),
      .src_d (src_d),
      .src_ok(src_ok)
    );

    xfer_reg_slot #(.WIDTH(WIDTH)) i_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_en(init_en),
      .init_d (init_data[d*WIDTH +: WIDTH]),
      .ld_en  (ld_en[d]),
      .xfer_ok(src_ok),
      .xfer_d (src_d),
      .q      (q_arr[d])
    );

    assert_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
      init_en |=> (q_arr[d] == $past(init_data[d*WIDTH +: WIDTH])));

    for (genvar k = 0; k < NSRC; k++) begin : g_route
      localparam int SRC = xfer_pkg::src_of(d, k);
      // R4, R6: destination takes the pre-edge value of its chosen source
      assert_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_en && ld_en[d] && sel_d == SELW'(k))
          |=> (q_arr[d] == $past(q_arr[SRC])));
    end
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_R1: assert (q_flat == '0);
  end

endmodule

// File: tb/test_xfer_fabric.sv
module test_xfer_fabric;
  localparam int  W = 8;
  localparam int  N = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG = 5000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           init_en;
  logic [N*W-1:0] init_data;
  logic [N-1:0]   ld_en;
  logic [N*2-1:0] src_sel;
  logic [N*W-1:0] reg_q;

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] model [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_fabric #(.WIDTH(W), .NREG(N)) i_xfer_fabric (
    .clk(clk), .rst_n(rst_n), .init_en(init_en), .init_data(init_data),
    .ld_en(ld_en), .src_sel(src_sel), .reg_q(reg_q)
  );

  function automatic int pick(input int dest, input int code);
    int cnt = 0;
    for (int j = 0; j < N; j++) begin
      if (j != dest) begin
        if (cnt == code) return j;
        cnt++;
      end
    end
    return -1;
  endfunction

  task automatic chk(input string req, input int idx, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s reg%0d actual=%h expected=%h", req, idx, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < N; i++) chk(req, i, reg_q[i*W +: W], model[i]);
  endtask

  task automatic step(input logic init, input logic [N*W-1:0] idata,
                      input logic [N-1:0] ld, input logic [N*2-1:0] sel);
    logic [W-1:0] old [N];
    @(negedge clk);
    init_en = init; init_data = idata; ld_en = ld; src_sel = sel;
    for (int i = 0; i < N; i++) old[i] = model[i];
    for (int i = 0; i < N; i++) begin
      int c = int'(sel[i*2 +: 2]);
      if (init) model[i] = idata[i*W +: W];
      else if (ld[i] && c < N-1) model[i] = old[pick(i, c)];
    end
    @(posedge clk); #1;
    init_en = 1'b0; ld_en = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; init_en = 1'b0; ld_en = '0; src_sel = '0; init_data = '0;
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (2) @(posedge clk);
    #1 chk_all("R1");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 chk_all("R1");
  endtask

  task automatic t_init();
    step(1'b1, {8'hD4, 8'hC3, 8'hB2, 8'hA1}, 4'b1111, 8'h00);
    chk_all("R2");
  endtask

  task automatic t_hold();
    step(1'b0, '0, 4'b0000, 8'h00);
    chk_all("R3");
    step(1'b0, '0, 4'b0001, 8'h00);  // only A loads, others keep
    chk_all("R3");
  endtask

  task automatic t_routes();
    for (int d = 0; d < N; d++) begin
      for (int k = 0; k < N-1; k++) begin
        step(1'b1, {8'h4D, 8'h3C, 8'h2B, 8'h1A}, '0, '0);
        step(1'b0, '0, N'(1) << d, 8'(k) << (2*d));
        chk_all("R4");
      end
    end
  endtask

  task automatic t_code3();
    step(1'b1, {8'hF0, 8'h0F, 8'h55, 8'hAA}, '0, '0);
    step(1'b0, '0, 4'b1111, 8'hFF);
    chk_all("R5");
  endtask

  task automatic t_swap();
    step(1'b1, {8'h44, 8'h33, 8'h22, 8'h11}, '0, '0);
    // A<-B (A code0), B<-A (B code0), C<-D (C code2), D<-C (D code2)
    step(1'b0, '0, 4'b1111, {2'd2, 2'd2, 2'd0, 2'd0});
    chk_all("R6");
  endtask

  task automatic t_rotate();
    step(1'b1, {8'h88, 8'h77, 8'h66, 8'h55}, '0, '0);
    // A<-B code0, B<-C code1, C<-D code2, D<-A code0
    step(1'b0, '0, 4'b1111, {2'd0, 2'd2, 2'd1, 2'd0});
    chk_all("R7");
    step(1'b0, '0, 4'b1111, {2'd0, 2'd2, 2'd1, 2'd0});
    chk_all("R7");
  endtask

  task automatic t_broadcast();
    step(1'b1, {8'h9D, 8'h9C, 8'h9B, 8'h9A}, '0, '0);
    // C into A (code1), B (code1), D (code2); C not loaded
    step(1'b0, '0, 4'b1011, {2'd2, 2'd0, 2'd1, 2'd1});
    chk_all("R8");
    // init wins over transfer requests
    step(1'b1, {8'h01, 8'h02, 8'h03, 8'h04}, 4'b1111, 8'h00);
    chk_all("R2");
  endtask

  initial begin
    t_reset();
    t_init();
    t_hold();
    t_routes();
    t_code3();
    t_swap();
    t_rotate();
    t_broadcast();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule